// File: doc/BRIEF.md
# Ethernet MAC Statistics Counter Bank

This block keeps thirty-seven statistics counters for the traffic of one Ethernet MAC. The transmit and receive paths each present a one-cycle strobe per finished frame. The strobe carries the frame length, the destination class, the VLAN tag kind, a vector of per-frame status flags and, on transmit only, an abort indication. From each strobe the block updates byte totals, packet totals, destination-class and status-event counts, and a set of frame-size bins. The size bins are shared by both directions.

A host reaches the bank through a simple register strobe port. Reads are registered, and the read data appears one cycle after the read strobe. Through this port the host reads any counter, enables clear-on-read, fires a clear of the whole bank, and reads or clears the sticky per-counter carry bits. It also sets the per-counter interrupt masks. When a counter wraps, its carry bit is latched. A single interrupt line is high while any latched carry bit has a clear mask bit. A FIFO-mode input limits counting to six core counters.

Top module: `mac_stat_bank`

## Requirements
- R1: After reset every counter, carry bit and mask bit is zero, clear-on-read is off, `irq` is low and `reg_rdata` is zero.
- R2: A transmit strobe adds `tx_len` to counter 0 and one to counter 1. A receive strobe adds `rx_len` to counter 13 and one to counter 14. Counter N is read at register address N.
- R3: A kind value of 1 (multicast) counts in counter 2 on transmit and 15 on receive. A kind value of 2 (broadcast) counts in counter 3 on transmit and 16 on receive. Transmit flag bit b (0 to 8) counts in counter 4+b, and receive flag bit b (0 to 12) counts in counter 17+b. Transmit bit 0 and receive bit 0 are drops, and receive bit 1 is an FCS error.
- R4: Each counted frame increments exactly one size bin by length: up to 64 goes to counter 30, 65–127 to 31, 128–255 to 32, 256–511 to 33, 512–1023 to 34, and 1024–1518 to 35. Reads with clear-on-read off leave counters unchanged.
- R5: A length of 1519–1522 counts in bin 36 only with tag value 1 (standard tag). With tag 0 (none) or tag 2 (custom), or with any length above 1522, the frame counts in no bin.
- R6: A transmit strobe with `tx_abort` high counts in no size bin but still counts bytes and packets. A transmit frame and a receive frame of the same bin in the same cycle add two to that bin.
- R7: While `fifo_mode` is high only counters 0, 1, 4, 13, 14 and 18 change. All others hold.
- R8: A counter whose addition passes its maximum keeps the wrapped sum and sets its sticky carry bit. Carry bits are read at address 0x48 (counters 0–31) and 0x49 (counters 32–36). Writing 1 to a carry bit clears it.
- R9: `irq` is high exactly when some carry bit is set and its mask bit is clear. Mask bits are written and read at 0x50 and 0x51 with the same bit layout as the carry bits, and a 1 masks.
- R10: Control register 0x40 bit 0 enables clear-on-read. A read then returns the old value and zeroes the counter. An increment in the same cycle as that read leaves the counter equal to the increment.
- R11: Writing 1 to control bit 1 zeroes every counter at once. This takes priority over an increment in the same cycle and leaves carry bits unchanged.
- R12: Writes to counter addresses have no effect, and read data is valid the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | Restrict counting to the six core counters |
| tx_vld | input | 1 | Transmit frame-done strobe |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_kind | input | 2 | Transmit destination class: 0 unicast, 1 multicast, 2 broadcast |
| tx_tag | input | 2 | Transmit tag: 0 none, 1 standard, 2 custom |
| tx_abort | input | 1 | Transmit frame aborted |
| tx_flags | input | 9 | Transmit status flags |
| rx_vld | input | 1 | Receive frame-done strobe |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_kind | input | 2 | Receive destination class |
| rx_tag | input | 2 | Receive tag kind |
| rx_flags | input | 13 | Receive status flags |
| reg_cs | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Unmasked carry pending |

## Verification
The bench builds the bank with 8-bit counters and keeps the default 32-bit data, 14-bit length and 8-bit address widths. Narrow counters bring wrap, carry latching, masking and W1C clearing within reach: two 200-byte frames overflow a byte counter. The full 32-bit register view of the carry and mask words stays the same as in the default build. Frame lengths at each bin edge and at 1518, 1519, 1522 and 1523 probe the size classification with every tag kind.

// File: rtl/mac_stat_pkg.sv
package mac_stat_pkg;

    localparam int NCNT      = 37;
    localparam int TXF_W     = 9;
    localparam int RXF_W     = 13;
    localparam int NBIN      = 7;
    localparam int LEN_MAX_W = 16;

    // counter slots
    localparam int IX_TXB  = 0;
    localparam int IX_TXP  = 1;
    localparam int IX_TXMC = 2;
    localparam int IX_TXBC = 3;
    localparam int IX_TXF  = 4;
    localparam int IX_RXB  = 13;
    localparam int IX_RXP  = 14;
    localparam int IX_RXMC = 15;
    localparam int IX_RXBC = 16;
    localparam int IX_RXF  = 17;
    localparam int IX_BIN  = 30;

    // register map
    localparam int A_CTRL  = 64;
    localparam int A_CARRY = 72;
    localparam int A_MASK  = 80;

    typedef enum logic [1:0] {K_UNI = 2'd0, K_MULTI = 2'd1, K_BCAST = 2'd2} kind_e;
    typedef enum logic [1:0] {TAG_NONE = 2'd0, TAG_STD = 2'd1, TAG_CUSTOM = 2'd2} tag_e;

    typedef struct packed {
        logic                 vld;
        logic [LEN_MAX_W-1:0] len;
        logic [1:0]           kind;
        logic [1:0]           tag;
        logic                 abort;
    } frm_t;

    function automatic logic [NBIN-1:0] size_bins(input frm_t f);
        logic [NBIN-1:0] b;
        b = '0;
        if (f.vld && !f.abort) begin
            if (f.len <= 16'd64)        b[0] = 1'b1;
            else if (f.len <= 16'd127)  b[1] = 1'b1;
            else if (f.len <= 16'd255)  b[2] = 1'b1;
            else if (f.len <= 16'd511)  b[3] = 1'b1;
            else if (f.len <= 16'd1023) b[4] = 1'b1;
            else if (f.len <= 16'd1518) b[5] = 1'b1;
            else if (f.len <= 16'd1522 && f.tag == TAG_STD) b[6] = 1'b1;
        end
        return b;
    endfunction

    function automatic bit fifo_kept(input int idx);
        return idx == IX_TXB || idx == IX_TXP || idx == IX_TXF ||
               idx == IX_RXB || idx == IX_RXP || idx == IX_RXF + 1;
    endfunction

endpackage

// File: rtl/mac_stat_decode.sv
module mac_stat_decode
    import mac_stat_pkg::*;
#(
    parameter int LEN_W = 14,
    parameter int INC_W = LEN_W + 1
) (
    input  logic                           fifo_mode,
    input  logic                           tx_vld,
    input  logic [LEN_W-1:0]               tx_len,
    input  logic [1:0]                     tx_kind,
    input  logic [1:0]                     tx_tag,
    input  logic                           tx_abort,
    input  logic [TXF_W-1:0]               tx_flags,
    input  logic                           rx_vld,
    input  logic [LEN_W-1:0]               rx_len,
    input  logic [1:0]                     rx_kind,
    input  logic [1:0]                     rx_tag,
    input  logic [RXF_W-1:0]               rx_flags,
    output logic [NCNT-1:0][INC_W-1:0]     inc
);

    frm_t                         tx_f, rx_f;
    logic [NBIN-1:0]              tx_bins, rx_bins;
    logic [NCNT-1:0][INC_W-1:0]   raw;

    assign tx_f = '{vld: tx_vld, len: LEN_MAX_W'(tx_len), kind: tx_kind, tag: tx_tag, abort: tx_abort};
    assign rx_f = '{vld: rx_vld, len: LEN_MAX_W'(rx_len), kind: rx_kind, tag: rx_tag, abort: 1'b0};

    assign tx_bins = size_bins(tx_f);
    assign rx_bins = size_bins(rx_f);

    always_comb begin
        raw = '0;
        if (tx_vld) begin
            raw[IX_TXB]  = INC_W'(tx_len);
            raw[IX_TXP]  = INC_W'(1);
            raw[IX_TXMC] = INC_W'(tx_kind == K_MULTI);
            raw[IX_TXBC] = INC_W'(tx_kind == K_BCAST);
            for (int b = 0; b < TXF_W; b++) raw[IX_TXF + b] = INC_W'(tx_flags[b]);
        end
        if (rx_vld) begin
            raw[IX_RXB]  = INC_W'(rx_len);
            raw[IX_RXP]  = INC_W'(1);
            raw[IX_RXMC] = INC_W'(rx_kind == K_MULTI);
            raw[IX_RXBC] = INC_W'(rx_kind == K_BCAST);
            for (int b = 0; b < RXF_W; b++) raw[IX_RXF + b] = INC_W'(rx_flags[b]);
        end
        for (int b = 0; b < NBIN; b++)
            raw[IX_BIN + b] = INC_W'(tx_bins[b]) + INC_W'(rx_bins[b]);
    end

    for (genvar i = 0; i < NCNT; i++) begin : g_gate
        if (fifo_kept(i)) begin : g_keep
            assign inc[i] = raw[i];
        end else begin : g_hold
            assign inc[i] = fifo_mode ? '0 : raw[i];
        end
    end

endmodule

// File: rtl/mac_stat_cell.sv
module mac_stat_cell #(
    parameter int CNT_W = 32,
    parameter int INC_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    input  logic             rd_clr,
    input  logic             clr_all,
    input  logic             carry_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             carry
);

    localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;

    logic [SUM_W-1:0] sum;
    logic             wrap;

    // a clearing read restarts from zero so a same-cycle event is kept
    assign sum  = SUM_W'(rd_clr ? '0 : cnt) + SUM_W'(inc);
    assign wrap = |sum[SUM_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            carry <= 1'b0;
        end else begin
            cnt <= clr_all ? '0 : sum[CNT_W-1:0];
            if (wrap && !clr_all)
                carry <= 1'b1;
            else if (carry_clr)
                carry <= 1'b0;
        end
    end

endmodule

// File: rtl/mac_stat_host.sv
module mac_stat_host
    import mac_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_cs,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    input  logic [NCNT-1:0][CNT_W-1:0]  cnt,
    input  logic [NCNT-1:0]             carry,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic                        cor,
    output logic                        clr_all,
    output logic [NCNT-1:0]             rd_clr,
    output logic [NCNT-1:0]             carry_clr,
    output logic [NCNT-1:0]             mask
);

    logic              rd, wr, ctrl_wr;
    logic [DATA_W-1:0] rd_val;

    assign rd      = reg_cs && !reg_we;
    assign wr      = reg_cs && reg_we;
    assign ctrl_wr = wr && reg_addr == ADDR_W'(A_CTRL);
    assign clr_all = ctrl_wr && reg_wdata[1];

    for (genvar i = 0; i < NCNT; i++) begin : g_bit
        localparam int WRD = i / DATA_W;
        localparam int BIT = i % DATA_W;

        assign rd_clr[i]    = rd && cor && reg_addr == ADDR_W'(i);
        assign carry_clr[i] = wr && reg_addr == ADDR_W'(A_CARRY + WRD) && reg_wdata[BIT];

        always_ff @(posedge clk) begin
            if (rst)
                mask[i] <= 1'b0;
            else if (wr && reg_addr == ADDR_W'(A_MASK + WRD))
                mask[i] <= reg_wdata[BIT];
        end
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NCNT; i++) begin
            if (reg_addr == ADDR_W'(i))
                rd_val = DATA_W'(cnt[i]);
        end
        if (reg_addr == ADDR_W'(A_CTRL))
            rd_val = DATA_W'(cor);
        for (int i = 0; i < NCNT; i++) begin
            if (reg_addr == ADDR_W'(A_CARRY + i / DATA_W))
                rd_val[i % DATA_W] = carry[i];
            if (reg_addr == ADDR_W'(A_MASK + i / DATA_W))
                rd_val[i % DATA_W] = mask[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            cor       <= 1'b0;
        end else begin
            if (rd)
                reg_rdata <= rd_val;
            if (ctrl_wr)
                cor <= reg_wdata[0];
        end
    end

endmodule

// File: rtl/mac_stat_bank.sv
module mac_stat_bank
    import mac_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 14,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_mode,
    input  logic              tx_vld,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [1:0]        tx_kind,
    input  logic [1:0]        tx_tag,
    input  logic              tx_abort,
    input  logic [8:0]        tx_flags,
    input  logic              rx_vld,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [1:0]        rx_kind,
    input  logic [1:0]        rx_tag,
    input  logic [12:0]       rx_flags,
    input  logic              reg_cs,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int INC_W = LEN_W + 1;

    logic [NCNT-1:0][INC_W-1:0] inc;
    logic [NCNT-1:0][CNT_W-1:0] cnt;
    logic [NCNT-1:0]            carry, mask, rd_clr, carry_clr;
    logic                       cor, clr_all;

    mac_stat_decode #(.LEN_W(LEN_W), .INC_W(INC_W)) u_dec (
        .fifo_mode (fifo_mode),
        .tx_vld    (tx_vld),
        .tx_len    (tx_len),
        .tx_kind   (tx_kind),
        .tx_tag    (tx_tag),
        .tx_abort  (tx_abort),
        .tx_flags  (tx_flags),
        .rx_vld    (rx_vld),
        .rx_len    (rx_len),
        .rx_kind   (rx_kind),
        .rx_tag    (rx_tag),
        .rx_flags  (rx_flags),
        .inc       (inc)
    );

    for (genvar i = 0; i < NCNT; i++) begin : g_cell
        mac_stat_cell #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cell (
            .clk       (clk),
            .rst       (rst),
            .inc       (inc[i]),
            .rd_clr    (rd_clr[i]),
            .clr_all   (clr_all),
            .carry_clr (carry_clr[i]),
            .cnt       (cnt[i]),
            .carry     (carry[i])
        );
    end

    mac_stat_host #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_host (
        .clk       (clk),
        .rst       (rst),
        .reg_cs    (reg_cs),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt       (cnt),
        .carry     (carry),
        .reg_rdata (reg_rdata),
        .cor       (cor),
        .clr_all   (clr_all),
        .rd_clr    (rd_clr),
        .carry_clr (carry_clr),
        .mask      (mask)
    );

    assign irq = |(carry & ~mask);

endmodule

// File: rtl/mac_stat_bank_chk.sv
module mac_stat_bank_chk
    import mac_stat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       fifo_mode,
    input logic                       tx_vld,
    input logic                       reg_cs,
    input logic                       reg_we,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [DATA_W-1:0]          reg_wdata,
    input logic                       irq,
    input logic                       cor,
    input logic [NCNT-1:0][CNT_W-1:0] cnt,
    input logic [NCNT-1:0]            carry
);

    logic            wipe, rd_mc;
    logic [NCNT-1:0] w1c;

    assign wipe  = reg_cs && reg_we && reg_addr == ADDR_W'(A_CTRL) && reg_wdata[1];
    assign rd_mc = reg_cs && !reg_we && cor && reg_addr == ADDR_W'(IX_TXMC);

    always_comb begin
        for (int i = 0; i < NCNT; i++)
            w1c[i] = reg_cs && reg_we && reg_addr == ADDR_W'(A_CARRY + i / DATA_W)
                     && reg_wdata[i % DATA_W];
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !irq && carry == '0);

    p_fifo_hold_r7: assert property (@(posedge clk) disable iff (rst)
        fifo_mode && !wipe && !rd_mc |=> $stable(cnt[IX_TXMC]));

    p_carry_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(carry & ~w1c) & ~carry) == '0));

    p_no_carry_no_irq_r9: assert property (@(posedge clk) disable iff (rst)
        carry == '0 |-> !irq);

    p_cor_zero_r10: assert property (@(posedge clk) disable iff (rst)
        rd_mc && !tx_vld && !wipe |=> cnt[IX_TXMC] == '0);

    p_clear_all_r11: assert property (@(posedge clk) disable iff (rst)
        wipe |=> cnt == '0);

endmodule

bind mac_stat_bank mac_stat_bank_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fifo_mode (fifo_mode),
    .tx_vld    (tx_vld),
    .reg_cs    (reg_cs),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .cor       (cor),
    .cnt       (cnt),
    .carry     (carry)
);

// File: tb/mac_stat_bank_tb.sv
`timescale 1ns/1ps
module mac_stat_bank_tb;

    localparam int CNT_W  = 8;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 14;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fifo_mode = 1'b0;
    logic              tx_vld = 1'b0, tx_abort = 1'b0;
    logic [LEN_W-1:0]  tx_len = '0;
    logic [1:0]        tx_kind = '0, tx_tag = '0;
    logic [8:0]        tx_flags = '0;
    logic              rx_vld = 1'b0;
    logic [LEN_W-1:0]  rx_len = '0;
    logic [1:0]        rx_kind = '0, rx_tag = '0;
    logic [12:0]       rx_flags = '0;
    logic              reg_cs = 1'b0, reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mac_stat_bank #(.CNT_W(CNT_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode),
        .tx_vld(tx_vld), .tx_len(tx_len), .tx_kind(tx_kind), .tx_tag(tx_tag),
        .tx_abort(tx_abort), .tx_flags(tx_flags),
        .rx_vld(rx_vld), .rx_len(rx_len), .rx_kind(rx_kind), .rx_tag(rx_tag),
        .rx_flags(rx_flags),
        .reg_cs(reg_cs), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b0; reg_addr = ADDR_W'(a);
        @(negedge clk);
        reg_cs = 1'b0;
        v = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
        @(negedge clk);
        reg_cs = 1'b0; reg_we = 1'b0;
    endtask

    task automatic put_tx(input int len, input int kind, input int tag, input bit ab, input logic [8:0] fl);
        tx_vld = 1'b1; tx_len = LEN_W'(len); tx_kind = 2'(kind); tx_tag = 2'(tag);
        tx_abort = ab; tx_flags = fl;
    endtask

    task automatic put_rx(input int len, input int kind, input int tag, input logic [12:0] fl);
        rx_vld = 1'b1; rx_len = LEN_W'(len); rx_kind = 2'(kind); rx_tag = 2'(tag); rx_flags = fl;
    endtask

    task automatic settle();
        @(negedge clk);
        tx_vld = 1'b0; rx_vld = 1'b0; tx_abort = 1'b0; tx_flags = '0; rx_flags = '0;
    endtask

    task automatic tx_frame(input int len, input int kind, input int tag, input bit ab, input logic [8:0] fl);
        @(negedge clk);
        put_tx(len, kind, tag, ab, fl);
        settle();
    endtask

    task automatic rx_frame(input int len, input int kind, input int tag, input logic [12:0] fl);
        @(negedge clk);
        put_rx(len, kind, tag, fl);
        settle();
    endtask

    task automatic wipe_all();
        wr(64, 32'h2);
        wr(72, 32'hFFFF_FFFF);
        wr(73, 32'hFFFF_FFFF);
        wr(80, 32'h0);
        wr(81, 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rdata", reg_rdata, 0);
        rd_chk("R1 cnt0", 0, 0);
        rd_chk("R1 cnt36", 36, 0);
        rd_chk("R1 ctrl", 64, 0);
        rd_chk("R1 carry", 72, 0);
        rd_chk("R1 mask hi", 81, 0);
    endtask

    task automatic t_basic();
        wipe_all();
        tx_frame(100, 0, 0, 0, '0);
        rx_frame(60, 2, 0, '0);
        rd_chk("R2 tx bytes", 0, 100);
        rd_chk("R2 tx pkts", 1, 1);
        rd_chk("R2 tx pkts reread no cor", 1, 1);
        rd_chk("R2 rx bytes", 13, 60);
        rd_chk("R2 rx pkts", 14, 1);
        rd_chk("R3 rx bcast", 16, 1);
        rd_chk("R3 tx mcast none", 2, 0);
    endtask

    task automatic t_flags();
        wipe_all();
        tx_frame(70, 1, 0, 0, 9'h020);
        tx_frame(70, 2, 0, 0, 9'h001);
        rx_frame(70, 1, 0, 13'h1000);
        rx_frame(70, 0, 0, 13'h0002);
        rd_chk("R3 tx mcast", 2, 1);
        rd_chk("R3 tx bcast", 3, 1);
        rd_chk("R3 tx flag5", 9, 1);
        rd_chk("R3 tx drop", 4, 1);
        rd_chk("R3 rx mcast", 15, 1);
        rd_chk("R3 rx flag12", 29, 1);
        rd_chk("R3 rx fcs", 18, 1);
        rd_chk("R4 bin127 four", 31, 4);
    endtask

    task automatic t_bins();
        int lens[11] = '{64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518};
        wipe_all();
        foreach (lens[k]) rx_frame(lens[k], 0, 0, '0);
        rd_chk("R4 bin64", 30, 1);
        rd_chk("R4 bin127", 31, 2);
        rd_chk("R4 bin255", 32, 2);
        rd_chk("R4 bin511", 33, 2);
        rd_chk("R4 bin1023", 34, 2);
        rd_chk("R4 bin1518", 35, 2);
        rd_chk("R4 bin1522 none", 36, 0);
    endtask

    task automatic t_vlan();
        wipe_all();
        rx_frame(1520, 0, 1, '0);
        rx_frame(1520, 0, 2, '0);
        rx_frame(1522, 0, 1, '0);
        rx_frame(1523, 0, 1, '0);
        rx_frame(1519, 0, 0, '0);
        rx_frame(1518, 0, 2, '0);
        rd_chk("R5 std tagged bin", 36, 2);
        rd_chk("R5 custom 1518 bin", 35, 1);
        rd_chk("R5 rx pkts", 14, 6);
    endtask

    task automatic t_abort();
        wipe_all();
        tx_frame(100, 0, 0, 1, '0);
        rd_chk("R6 aborted no bin", 31, 0);
        rd_chk("R6 aborted pkt", 1, 1);
        @(negedge clk);
        put_tx(100, 0, 0, 0, '0);
        put_rx(110, 0, 0, '0);
        settle();
        rd_chk("R6 both dirs bin", 31, 2);
    endtask

    task automatic t_fifo();
        wipe_all();
        fifo_mode = 1'b1;
        @(negedge clk);
        put_tx(10, 1, 0, 0, 9'h021);
        put_rx(20, 1, 0, 13'h0022);
        settle();
        fifo_mode = 1'b0;
        rd_chk("R7 tx bytes", 0, 10);
        rd_chk("R7 tx pkts", 1, 1);
        rd_chk("R7 tx drop", 4, 1);
        rd_chk("R7 tx mcast held", 2, 0);
        rd_chk("R7 tx flag5 held", 9, 0);
        rd_chk("R7 rx bytes", 13, 20);
        rd_chk("R7 rx pkts", 14, 1);
        rd_chk("R7 rx fcs", 18, 1);
        rd_chk("R7 rx align held", 22, 0);
        rd_chk("R7 bin held", 30, 0);
    endtask

    task automatic t_carry();
        wipe_all();
        tx_frame(200, 0, 0, 0, '0);
        chk("R9 irq before wrap", 32'(irq), 0);
        tx_frame(200, 0, 0, 0, '0);
        rd_chk("R8 wrapped sum", 0, 144);
        rd_chk("R8 carry word", 72, 1);
        chk("R9 irq on wrap", 32'(irq), 1);
        wr(80, 32'h1);
        chk("R9 irq masked", 32'(irq), 0);
        rd_chk("R9 mask readback", 80, 1);
        wr(80, 32'h0);
        chk("R9 irq unmasked", 32'(irq), 1);
        tx_frame(10, 0, 0, 0, '0);
        rd_chk("R8 sticky", 72, 1);
        wr(72, 32'h1);
        rd_chk("R8 w1c", 72, 0);
        chk("R9 irq after w1c", 32'(irq), 0);
        wr(80, 32'h2000);
        rx_frame(200, 0, 0, '0);
        rx_frame(200, 0, 0, '0);
        rd_chk("R8 rx carry", 72, 32'h2000);
        chk("R9 masked rx wrap", 32'(irq), 0);
    endtask

    task automatic t_cor();
        wipe_all();
        wr(64, 32'h1);
        rd_chk("R10 ctrl readback", 64, 1);
        tx_frame(40, 0, 0, 0, '0);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b0; reg_addr = 8'd0;
        put_tx(30, 0, 0, 0, '0);
        settle();
        reg_cs = 1'b0;
        chk("R10 read old value", reg_rdata, 40);
        rd_chk("R10 kept increment", 0, 30);
        rd_chk("R10 zero after read", 0, 0);
        wr(64, 32'h0);
    endtask

    task automatic t_clear_all();
        wipe_all();
        tx_frame(200, 0, 0, 0, '0);
        tx_frame(200, 0, 0, 0, '0);
        rx_frame(20, 0, 0, '0);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b1; reg_addr = 8'd64; reg_wdata = 32'h2;
        put_tx(50, 0, 0, 0, '0);
        settle();
        reg_cs = 1'b0; reg_we = 1'b0;
        rd_chk("R11 tx bytes", 0, 0);
        rd_chk("R11 tx pkts", 1, 0);
        rd_chk("R11 rx bytes", 13, 0);
        rd_chk("R11 bin", 30, 0);
        rd_chk("R11 carry kept", 72, 1);
    endtask

    task automatic t_wr_ignore();
        wipe_all();
        tx_frame(5, 0, 0, 0, '0);
        wr(0, 32'h55);
        rd_chk("R12 write ignored", 0, 5);
        @(negedge clk);
        reg_cs = 1'b1; reg_we = 1'b0; reg_addr = 8'd1;
        @(posedge clk);
        #1;
        chk("R12 data after edge", reg_rdata, 1);
        @(negedge clk);
        reg_cs = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_flags();
        t_bins();
        t_vlan();
        t_abort();
        t_fifo();
        t_carry();
        t_cor();
        t_clear_all();
        t_wr_ignore();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule